// File: doc/BRIEF.md
# Memory-Mapped Real-Time Clock Core

This block keeps wall-clock time as a 32-bit seconds count and a milliseconds count. Both advance on a slow tick enable of nominally 32 kHz. A fractional accumulator converts ticks to milliseconds, so one second of ticks always yields exactly one second of time. Software sees the time through a small word-addressed register port. The registers visible on that port are refreshed from the running counters only once every eighth tick. A busy flag reports each refresh window.

Reading the milliseconds register also copies the visible seconds value into a shadow register. The shadow register can then be read to get a seconds/milliseconds pair that belong together. Two seconds-match alarms and one milliseconds-match alarm set write-one-to-clear status flags. A mask selects which flags drive the level-high interrupt output. Writes are meant for the quiet time between refresh windows. A write that lands inside a window is held and applied when the window closes.

Top module: `rtc_core`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq` is low.
- R2: Each tick adds MS_PER_S to an accumulator that wraps at TICK_HZ, and every wrap advances milliseconds by one. After n ticks, the count is floor(n*MS_PER_S/TICK_HZ) ms (defaults 1000 and 32768). Milliseconds wrap from MS_PER_S-1 to 0 and carry into seconds.
- R3: Bit 0 of byte offset 0x004 is the busy flag. It reads 1 for BUSY_CYC cycles, starting the cycle after every TICKS_PER_UPD-th tick (default 8). On the last of those cycles, the seconds (0x008) and milliseconds (0x010) registers take the counter values.
- R4: A read of 0x010 copies the value then in 0x008 into the shadow register at 0x00C, readable from the next cycle. The shadow register holds that value until the next read of 0x010.
- R5: A write to 0x008 loads the seconds counter and leaves the milliseconds phase running. The new value appears at 0x008 after the next refresh.
- R6: A write made while busy is 1 is held and applied at the end of the window. Until then, its target reads the old value.
- R7: Seconds alarm 0 (0x014) sets status bit 0, and seconds alarm 1 (0x018) sets status bit 1, on a refresh in which 0x008 changes to equal the alarm. An alarm value of 0 never fires.
- R8: The milliseconds alarm (0x01C) sets status bit 2 on a refresh in which 0x010 changes to equal it.
- R9: The status register (0x02C) is write-one-to-clear. Zero bits in the written data leave flags untouched. Bits 3 and 4 (countdown flags) and all higher bits read 0.
- R10: The mask register (0x028) stores bits 0..2 and reads 0 elsewhere. `irq` is high whenever a status bit and its mask bit are both 1.
- R11: Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle slow tick enable |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the shadow capture) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level-high interrupt |

## Verification
Read data is combinational, so a register write is visible one cycle later. A shadow capture is readable on the cycle after the milliseconds read. Counter values and alarm flags, together with `irq`, change only on the edge that ends a refresh window, BUSY_CYC cycles after the triggering tick. The bench therefore follows every tick with more idle cycles than the window length. It then samples one nanosecond after a falling edge. In the held-write case, it steps cycle by cycle and checks the busy flag and the old register value at each step before the window closes.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
// rtc_pkg: shared register offsets, interrupt bit positions and the
// internal write-commit record used by the real-time clock core.
package rtc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // Byte offsets of the register port.
    localparam logic [ADDR_W-1:0] A_BUSY   = 8'h04;
    localparam logic [ADDR_W-1:0] A_SEC    = 8'h08;
    localparam logic [ADDR_W-1:0] A_SHADOW = 8'h0C;
    localparam logic [ADDR_W-1:0] A_MSEC   = 8'h10;
    localparam logic [ADDR_W-1:0] A_SALM0  = 8'h14;
    localparam logic [ADDR_W-1:0] A_MALM   = 8'h1C;
    localparam logic [ADDR_W-1:0] A_MASK   = 8'h28;
    localparam logic [ADDR_W-1:0] A_STAT   = 8'h2C;

    // Interrupt flag layout (mask and status share it).
    localparam int IRQ_W      = 5;
    localparam int N_SEC_ALM  = 2;
    localparam int IB_MALM    = 2;
    localparam logic [IRQ_W-1:0] IRQ_IMPL = 5'b00111;

    // A write that is allowed to change state this cycle.
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } rtc_wr_t;
endpackage

// File: rtl/rtc_timebase.sv
`timescale 1ns/1ps
// rtc_timebase: running seconds and milliseconds counters.
// Each tick adds MS_PER_S to an accumulator modulo TICK_HZ; an overflow is
// one millisecond. Assumes MS_PER_S <= TICK_HZ. A load of the seconds
// counter wins over a carry in the same cycle and keeps the ms phase.
module rtc_timebase #(
    parameter int TICK_HZ  = 32768,
    parameter int MS_PER_S = 1000,
    parameter int MS_W     = $clog2(MS_PER_S)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     sec_load,
    input  logic [rtc_pkg::DATA_W-1:0] sec_load_val,
    output logic [rtc_pkg::DATA_W-1:0] sec_o,
    output logic [MS_W-1:0]          msec_o
);
    localparam int ACC_W = $clog2(2 * TICK_HZ);
    localparam logic [ACC_W-1:0] TICK_C  = ACC_W'(TICK_HZ);
    localparam logic [ACC_W-1:0] MS_C    = ACC_W'(MS_PER_S);
    localparam logic [MS_W-1:0]  MS_LAST = MS_W'(MS_PER_S - 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic             ms_step;
    logic             ms_wrap;

    // Accumulator sum and millisecond carry decision.
    always_comb begin
        acc_sum = acc_q + MS_C;
        ms_step = tick && (acc_sum >= TICK_C);
        ms_wrap = ms_step && (msec_o == MS_LAST);
    end

    // Fractional accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (tick) acc_q <= (acc_sum >= TICK_C) ? acc_sum - TICK_C : acc_sum;
    end

    // Milliseconds counter with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       msec_o <= '0;
        else if (ms_wrap) msec_o <= '0;
        else if (ms_step) msec_o <= msec_o + 1'b1;
    end

    // Seconds counter: load beats carry.
    always_ff @(posedge clk) begin
        if (!rst_n)        sec_o <= '0;
        else if (sec_load) sec_o <= sec_load_val;
        else if (ms_wrap)  sec_o <= sec_o + 1'b1;
    end
endmodule

// File: rtl/rtc_upd_window.sv
`timescale 1ns/1ps
// rtc_upd_window: counts slow ticks and opens a refresh window of BUSY_CYC
// bus cycles after every TICKS_PER_UPD-th tick. upd_o marks the window's
// last cycle, on which the visible registers are refreshed.
// Assumes ticks are spaced by more than BUSY_CYC cycles.
module rtc_upd_window #(
    parameter int TICKS_PER_UPD = 8,
    parameter int BUSY_CYC      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic busy_o,
    output logic upd_o
);
    localparam int TC_W = $clog2(TICKS_PER_UPD);
    localparam int BC_W = $clog2(BUSY_CYC + 1);
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(TICKS_PER_UPD - 1);
    localparam logic [BC_W-1:0] BC_LOAD = BC_W'(BUSY_CYC);

    logic [TC_W-1:0] tick_cnt_q;
    logic [BC_W-1:0] busy_cnt_q;
    logic            open_win;

    // Window opens on the last tick of a group.
    assign open_win = tick && (tick_cnt_q == TC_LAST);

    // Tick group counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        tick_cnt_q <= '0;
        else if (open_win) tick_cnt_q <= '0;
        else if (tick)     tick_cnt_q <= tick_cnt_q + 1'b1;
    end

    // Busy window down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                 busy_cnt_q <= '0;
        else if (open_win)          busy_cnt_q <= BC_LOAD;
        else if (busy_cnt_q != '0)  busy_cnt_q <= busy_cnt_q - 1'b1;
    end

    assign busy_o = (busy_cnt_q != '0);
    assign upd_o  = (busy_cnt_q == BC_W'(1));
endmodule

// File: rtl/rtc_write_gate.sv
`timescale 1ns/1ps
// rtc_write_gate: passes writes straight through outside the refresh
// window, holds one write made inside it and releases it on the window's
// last cycle. A later write in the same window replaces the held one.
module rtc_write_gate (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [rtc_pkg::ADDR_W-1:0]  addr,
    input  logic [rtc_pkg::DATA_W-1:0]  wdata,
    input  logic                        busy,
    input  logic                        upd,
    output rtc_pkg::rtc_wr_t            commit_o
);
    import rtc_pkg::*;

    rtc_wr_t held_q;
    rtc_wr_t incoming;

    assign incoming = '{vld: wr, addr: addr, data: wdata};

    // Choose what is allowed to change state this cycle.
    always_comb begin
        if (!busy)       commit_o = incoming;
        else if (upd)    commit_o = wr ? incoming : held_q;
        else             commit_o = '0;
    end

    // Holding register for writes made inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                  held_q <= '0;
        else if (upd)                held_q <= '0;
        else if (busy && wr)         held_q <= incoming;
    end
endmodule

// File: rtl/rtc_alarm_irq.sv
`timescale 1ns/1ps
// rtc_alarm_irq: alarm compare registers, interrupt mask and W1C status.
// Alarms are evaluated only on refresh cycles by comparing the value being
// copied out with the value currently visible ("becomes equal").
// A flag set beats a clear that lands in the same cycle.
module rtc_alarm_irq (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  rtc_pkg::rtc_wr_t                       commit,
    input  logic                                   upd,
    input  logic [rtc_pkg::DATA_W-1:0]             sec_new,
    input  logic [rtc_pkg::DATA_W-1:0]             sec_old,
    input  logic [rtc_pkg::DATA_W-1:0]             msec_new,
    input  logic [rtc_pkg::DATA_W-1:0]             msec_old,
    output logic [rtc_pkg::N_SEC_ALM-1:0][rtc_pkg::DATA_W-1:0] salm_o,
    output logic [rtc_pkg::DATA_W-1:0]             malm_o,
    output logic [rtc_pkg::IRQ_W-1:0]              mask_o,
    output logic [rtc_pkg::IRQ_W-1:0]              status_o,
    output logic                                   irq_o
);
    import rtc_pkg::*;

    logic [N_SEC_ALM-1:0] sec_hit;
    logic                 msec_hit;
    logic [IRQ_W-1:0]     set_vec;
    logic [IRQ_W-1:0]     clr_vec;

    // One compare register and match detector per seconds alarm.
    for (genvar i = 0; i < N_SEC_ALM; i++) begin : g_salm
        localparam logic [ADDR_W-1:0] A_THIS = A_SALM0 + ADDR_W'(4 * i);

        // Seconds alarm register write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   salm_o[i] <= '0;
            else if (commit.vld && commit.addr == A_THIS) salm_o[i] <= commit.data;
        end

        assign sec_hit[i] = upd && (salm_o[i] != '0) &&
                            (sec_new == salm_o[i]) && (sec_old != salm_o[i]);
    end

    // Milliseconds alarm register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   malm_o <= '0;
        else if (commit.vld && commit.addr == A_MALM) malm_o <= commit.data;
    end

    assign msec_hit = upd && (msec_new == malm_o) && (msec_old != malm_o);

    // Gather flag sets and W1C clears.
    always_comb begin
        set_vec                  = '0;
        set_vec[N_SEC_ALM-1:0]   = sec_hit;
        set_vec[IB_MALM]         = msec_hit;
        clr_vec = (commit.vld && commit.addr == A_STAT) ? commit.data[IRQ_W-1:0] : '0;
    end

    // Status flags: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= ((status_o & ~clr_vec) | set_vec) & IRQ_IMPL;
    end

    // Interrupt mask: only implemented bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   mask_o <= '0;
        else if (commit.vld && commit.addr == A_MASK) mask_o <= commit.data[IRQ_W-1:0] & IRQ_IMPL;
    end

    assign irq_o = |(status_o & mask_o);
endmodule

// File: rtl/rtc_core.sv
`timescale 1ns/1ps
// rtc_core: top of the real-time clock. Holds the bus-visible copies of the
// counters, the shadow seconds register and the read multiplexer.
// Assumes one tick per several bus cycles and word-aligned offsets.
module rtc_core #(
    parameter int TICK_HZ       = 32768,
    parameter int MS_PER_S      = 1000,
    parameter int TICKS_PER_UPD = 8,
    parameter int BUSY_CYC      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_32k,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    import rtc_pkg::*;

    localparam int MS_W = $clog2(MS_PER_S);

    logic                 busy_w;
    logic                 upd_w;
    rtc_wr_t              commit_w;
    logic [DATA_W-1:0]    core_sec;
    logic [MS_W-1:0]      core_msec;
    logic [DATA_W-1:0]    core_msec_x;
    logic [DATA_W-1:0]    vis_sec_q;
    logic [DATA_W-1:0]    vis_msec_q;
    logic [DATA_W-1:0]    shadow_q;
    logic [N_SEC_ALM-1:0][DATA_W-1:0] salm_w;
    logic [DATA_W-1:0]    malm_w;
    logic [IRQ_W-1:0]     mask_w;
    logic [IRQ_W-1:0]     status_w;
    logic                 sec_load;

    assign sec_load    = commit_w.vld && (commit_w.addr == A_SEC);
    assign core_msec_x = DATA_W'(core_msec);

    rtc_upd_window #(.TICKS_PER_UPD(TICKS_PER_UPD), .BUSY_CYC(BUSY_CYC)) u_win (
        .clk(clk), .rst_n(rst_n), .tick(tick_32k), .busy_o(busy_w), .upd_o(upd_w)
    );

    rtc_write_gate u_gate (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .busy(busy_w), .upd(upd_w), .commit_o(commit_w)
    );

    rtc_timebase #(.TICK_HZ(TICK_HZ), .MS_PER_S(MS_PER_S), .MS_W(MS_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick_32k), .sec_load(sec_load),
        .sec_load_val(commit_w.data), .sec_o(core_sec), .msec_o(core_msec)
    );

    rtc_alarm_irq u_alm (
        .clk(clk), .rst_n(rst_n), .commit(commit_w), .upd(upd_w),
        .sec_new(core_sec), .sec_old(vis_sec_q),
        .msec_new(core_msec_x), .msec_old(vis_msec_q),
        .salm_o(salm_w), .malm_o(malm_w), .mask_o(mask_w),
        .status_o(status_w), .irq_o(irq)
    );

    // Bus-visible counter copies, refreshed at the end of each window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_sec_q  <= '0;
            vis_msec_q <= '0;
        end else if (upd_w) begin
            vis_sec_q  <= core_sec;
            vis_msec_q <= core_msec_x;
        end
    end

    // Shadow seconds: captured by a milliseconds read.
    always_ff @(posedge clk) begin
        if (!rst_n)                               shadow_q <= '0;
        else if (bus_rd && (bus_addr == A_MSEC))  shadow_q <= vis_sec_q;
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_BUSY:                   bus_rdata = DATA_W'(busy_w);
            A_SEC:                    bus_rdata = vis_sec_q;
            A_SHADOW:                 bus_rdata = shadow_q;
            A_MSEC:                   bus_rdata = vis_msec_q;
            A_SALM0:                  bus_rdata = salm_w[0];
            A_SALM0 + ADDR_W'(4):     bus_rdata = salm_w[1];
            A_MALM:                   bus_rdata = malm_w;
            A_MASK:                   bus_rdata = DATA_W'(mask_w);
            A_STAT:                   bus_rdata = DATA_W'(status_w);
            default:                  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_core_chk.sv
`timescale 1ns/1ps
// rtc_core_chk: temporal properties of the clock core, bound to rtc_core.
module rtc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        busy,
    input logic        upd,
    input logic        commit_vld,
    input logic [31:0] vis_sec,
    input logic [31:0] shadow,
    input logic [4:0]  status,
    input logic        bus_rd,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic        irq
);
    import rtc_pkg::*;

    // R3: a window only opens right after a tick.
    a_r3_busy_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tick));

    // R3: the refresh cycle lies inside the busy window.
    a_r3_upd_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> busy);

    // R5: visible seconds change only on a refresh cycle.
    a_r5_sec_moves_on_upd: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(vis_sec));

    // R6: no write takes effect inside the window except at its end.
    a_r6_commit_outside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_vld && busy) |-> upd);

    // R4: shadow holds unless a milliseconds read occurs.
    a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == A_MSEC) |=> $stable(shadow));

    // R9: countdown flag bits and above read as zero.
    a_r9_status_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STAT) |-> (bus_rdata[31:3] == '0));

    // R10: an interrupt always has a pending flag behind it.
    a_r10_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));
endmodule

bind rtc_core rtc_core_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .busy(busy_w), .upd(upd_w),
    .commit_vld(commit_w.vld), .vis_sec(vis_sec_q), .shadow(shadow_q),
    .status(status_w), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .irq(irq)
);

// File: tb/rtc_core_tb_top.sv
`timescale 1ns/1ps
// rtc_core_tb_top: directed corners plus seeded random traffic, checked
// against a behavioural model kept in bench variables.
module rtc_core_tb_top;
    localparam int TICK_HZ = 96;
    localparam int MSPS    = 10;
    localparam int TPU     = 8;
    localparam int BCYC    = 4;

    localparam logic [7:0] O_BUSY = 8'h04, O_SEC = 8'h08, O_SHD = 8'h0C,
                           O_MS = 8'h10, O_SA0 = 8'h14, O_SA1 = 8'h18,
                           O_MA = 8'h1C, O_MASK = 8'h28, O_STAT = 8'h2C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_32k = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    // Model state.
    longint      ticks = 0;
    longint      sec_off = 0;
    logic [31:0] m_sec = 0, m_ms = 0, m_shd = 0, m_sa0 = 0, m_sa1 = 0, m_ma = 0;
    logic [31:0] m_mask = 0, m_stat = 0;

    always #4 clk = ~clk;

    rtc_core #(.TICK_HZ(TICK_HZ), .MS_PER_S(MSPS), .TICKS_PER_UPD(TPU), .BUSY_CYC(BCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic longint tot_ms(longint n);
        return (n * MSPS) / TICK_HZ;
    endfunction

    function automatic logic [31:0] core_sec(longint n);
        return 32'(tot_ms(n) / MSPS + sec_off);
    endfunction

    function automatic logic [31:0] core_ms(longint n);
        return 32'(tot_ms(n) % MSPS);
    endfunction

    // Refresh of the visible copies plus alarm evaluation (R3, R7, R8).
    function automatic void model_update();
        logic [31:0] ns = core_sec(ticks);
        logic [31:0] nm = core_ms(ticks);
        if (m_sa0 != 0 && ns == m_sa0 && m_sec != m_sa0) m_stat[0] = 1'b1;
        if (m_sa1 != 0 && ns == m_sa1 && m_sec != m_sa1) m_stat[1] = 1'b1;
        if (nm == m_ma && m_ms != m_ma) m_stat[2] = 1'b1;
        m_sec = ns;
        m_ms  = nm;
    endfunction

    function automatic void model_write(logic [7:0] a, logic [31:0] d);
        case (a)
            O_SEC:  sec_off = longint'(d) - tot_ms(ticks) / MSPS;
            O_SA0:  m_sa0 = d;
            O_SA1:  m_sa1 = d;
            O_MA:   m_ma = d;
            O_MASK: m_mask = d & 32'h7;
            O_STAT: m_stat = m_stat & ~d;
            default: ;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick1();
        @(negedge clk) tick_32k = 1'b1;
        @(negedge clk) tick_32k = 1'b0;
        repeat (BCYC) @(negedge clk);
        ticks++;
        if (ticks % TPU == 0) model_update();
    endtask

    task automatic ticks_n(int n);
        for (int i = 0; i < n; i++) tick1();
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk) #1 bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
        logic [31:0] v;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        chk(req, v, exp);
        @(posedge clk) #1 bus_rd = 1'b0;
        if (a == O_MS) m_shd = m_sec;
    endtask

    task automatic peek(logic [7:0] a, logic [31:0] exp, string req);
        bus_addr = a;
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic irq_chk(string req);
        @(negedge clk);
        #1 chk(req, 32'(irq), 32'(|(m_stat & m_mask)));
    endtask

    // Watchdog: a hang counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every mapped register and irq.
        rd(O_BUSY, 0, "R1 busy"); rd(O_SEC, 0, "R1 sec"); rd(O_SHD, 0, "R1 shadow");
        rd(O_MS, 0, "R1 msec"); rd(O_SA0, 0, "R1 salm0"); rd(O_SA1, 0, "R1 salm1");
        rd(O_MA, 0, "R1 malm"); rd(O_MASK, 0, "R1 mask"); rd(O_STAT, 0, "R1 status");
        irq_chk("R1 irq");

        // Alarm set-up: seconds alarm 0 at 1 s, alarm 1 left at 0, ms alarm at 5.
        wr(O_SA0, 1); wr(O_MA, 5);
        rd(O_SA0, 1, "R7 salm0 readback"); rd(O_MA, 5, "R8 malm readback");

        // R3 / R6: busy window and a write held inside it.
        ticks_n(TPU - 1);
        @(negedge clk) peek(O_BUSY, 0, "R3 idle before group end");
        @(negedge clk) tick_32k = 1'b1;
        @(negedge clk) tick_32k = 1'b0;
        bus_addr = O_MASK; bus_wdata = 32'h7; bus_wr = 1'b1;
        @(negedge clk) bus_wr = 1'b0;
        peek(O_MASK, 0, "R6 held write not yet visible");
        peek(O_BUSY, 1, "R3 busy in window");
        @(negedge clk);
        @(negedge clk) peek(O_BUSY, 1, "R3 busy last cycle");
        @(negedge clk) peek(O_BUSY, 0, "R3 busy ends");
        peek(O_MASK, 7, "R6 held write applied");
        ticks++; model_update(); m_mask = 32'h7;

        // R8: milliseconds alarm.
        ticks_n(40 - TPU);
        rd(O_STAT, m_stat, "R8 no flag early");
        rd(O_MS, m_ms, "R2 msec at 40 ticks");
        ticks_n(8);
        rd(O_STAT, 32'h4, "R8 ms alarm flag");
        irq_chk("R10 irq from ms alarm");
        wr(O_STAT, 32'h4);
        rd(O_STAT, 0, "R9 W1C clears");
        irq_chk("R10 irq drops");

        // R2 / R7: first carry into seconds triggers alarm 0.
        ticks_n(96 - 48);
        rd(O_SEC, 1, "R2 one second"); rd(O_MS, 0, "R2 msec wrapped");
        rd(O_STAT, 32'h1, "R7 sec alarm0 flag, alarm1 at 0 silent");
        irq_chk("R10 irq from sec alarm");
        wr(O_STAT, 32'h2);
        rd(O_STAT, 32'h1, "R9 zero bits keep flag");
        wr(O_STAT, 32'hFFFF_FFFF);
        rd(O_STAT, 0, "R9 all cleared");

        // R5: seconds load shows after next refresh.
        wr(O_SEC, 1000);
        rd(O_SEC, m_sec, "R5 old value until refresh");
        ticks_n(TPU);
        rd(O_SEC, m_sec, "R5 loaded value");
        chk("R5 model sanity", m_sec, 32'd1000 + 32'(tot_ms(ticks) / MSPS - tot_ms(ticks - TPU) / MSPS));

        // R4: shadow capture and hold.
        rd(O_MS, m_ms, "R4 msec read");
        rd(O_SHD, m_shd, "R4 shadow captured");
        ticks_n(2 * 96);
        rd(O_SHD, m_shd, "R4 shadow held");
        rd(O_MS, m_ms, "R4 msec read again");
        rd(O_SHD, m_sec, "R4 shadow refreshed");

        // R10 / R11: mask width and unmapped offsets.
        wr(O_MASK, 32'hFFFF_FFFF);
        rd(O_MASK, 32'h7, "R10 mask reserved bits");
        wr(8'h20, 32'hDEAD_BEEF); wr(8'h24, 32'h1234_5678);
        rd(8'h20, 0, "R11 unmapped 0x20"); rd(8'h00, 0, "R11 unmapped 0x00");
        rd(8'h30, 0, "R11 unmapped 0x30");
        rd(O_MASK, 32'h7, "R11 write had no effect"); rd(O_SA0, 1, "R11 alarm intact");

        // Random traffic against the model.
        for (int it = 0; it < 60; it++) begin
            ticks_n($urandom_range(1, 20));
            case ($urandom_range(0, 3))
                0: rd(O_SEC, m_sec, "R2 random sec");
                1: begin rd(O_MS, m_ms, "R2 random msec"); rd(O_SHD, m_shd, "R4 random shadow"); end
                2: wr(O_SA1, m_sec + 32'($urandom_range(0, 2)));
                default: begin
                    rd(O_STAT, m_stat, "R7 random status");
                    irq_chk("R10 random irq");
                    wr(O_STAT, 32'($urandom_range(0, 7)));
                end
            endcase
        end
        rd(O_STAT, m_stat, "R7 final status");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule